// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller with Programming Permission

This block is the serial test port of a device: a sixteen-state test access port machine clocked by the test clock and steered by the mode-select line. It also holds a 4-bit instruction register and three data paths: a one-bit pass-through stage, a 32-bit identification word and a boundary register whose length is a parameter. Instructions are shifted in serially and decoded when the instruction update state is reached. The decoded instruction picks the data path that sits between the serial input and output. It also drives the controls that the surrounding pad logic uses: the boundary capture and update strobes, the external-test drive select and a request that puts every system output into high impedance.

The port has no separate reset pin. An asynchronous power-on reset, or five clocks with mode-select high, returns the machine to its reset state. Four extra instructions serve in-system programming: one grants permission, and the erase, program and verify commands act only while that permission is held. The permission survives across later instructions and is withdrawn only when the machine passes through its reset state. The nonvolatile cells and the high-voltage generator are outside this block. It only reports which programming command has been accepted.

Top module: `jtag_isp_tap`

## Requirements
- R1: The controller follows the standard test access port state graph on each rising test clock, and `tap_state` reports the state as: reset 0, idle 1, select-DR 2, capture-DR 3, shift-DR 4, exit1-DR 5, pause-DR 6, exit2-DR 7, update-DR 8, select-IR 9, capture-IR 10, shift-IR 11, exit1-IR 12, pause-IR 13, exit2-IR 14, update-IR 15. Mode-select held high keeps the reset state, and five high clocks reach it from any state.
- R2: While `por_n` is low, the controller is held in the reset state, IDCODE is the active instruction, programming permission is cleared and `tdo_oe` is low, all without a clock. Each rising clock in the reset state also restores IDCODE and clears the permission.
- R3: Capture-IR loads 0001 into the instruction shift stage. Shift-IR moves bits out least significant first, taking each new bit from `tdi`. Update-IR makes the shifted value the active instruction.
- R4: Opcodes: 0000 external test, 0001 IDCODE, 0010 sample/preload, 0101 high impedance, 1111 bypass (so a scan of all ones selects bypass). Every opcode with no function decodes as bypass, which captures 0 and delays `tdi` by exactly one shift clock.
- R5: Under IDCODE, Capture-DR loads the `IDCODE` parameter (default 32'h1A5C3093, bit 0 set), and the word is shifted out least significant bit first.
- R6: `tdo` and `tdo_oe` change only on the falling test clock edge. `tdo_oe` is high exactly while the controller is in shift-IR or shift-DR, and `tdo` then presents the bit at the output end of the selected shift stage.
- R7: While high impedance (0101) is the active instruction, `global_hiz` is high and the data path is the one-bit pass-through stage.
- R8: An update-IR with opcode 1000 (ENABLE, a parameter) sets `isp_enabled`. The flag stays set through any later instructions and clears only in the reset state or on `por_n`.
- R9: Opcodes 1001 erase, 1010 program and 1011 verify (parameters) are accepted at update-IR only when `isp_enabled` is already set. An accepted command raises `isp_cmd_valid` with `isp_cmd` = 01, 10 or 11 respectively. A rejected one acts as bypass with `isp_cmd_valid` low and `isp_cmd` = 00.
- R10: Under external test or sample/preload, Capture-DR loads `bsr_pins` (bit 0 shifts out first) with `bs_capture` high, and Update-DR copies the shift stage to `bsr_out` with `bs_update` high. `extest_mode` is high only under external test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` (low means high impedance) |
| tap_state | output | 4 | Current controller state code |
| bsr_pins | input | BSR_LEN | Pin values captured into the boundary register |
| bsr_out | output | BSR_LEN | Boundary update register toward the pads |
| bs_capture | output | 1 | Boundary capture strobe |
| bs_update | output | 1 | Boundary update strobe |
| extest_mode | output | 1 | Pads driven from `bsr_out` |
| global_hiz | output | 1 | Request to float every system output |
| isp_enabled | output | 1 | Programming permission held |
| isp_cmd_valid | output | 1 | A programming command is accepted and active |
| isp_cmd | output | 2 | Accepted programming command code |

## Verification
The hardest case to reach from the pins is the life cycle of the programming permission. It must be refused before any ENABLE, survive unrelated instructions once granted, and vanish only after a pass through the reset state, never on a plain return to idle. The stimulus runs erase before any ENABLE, then ENABLE, program, bypass and verify, walks five high mode-select clocks into reset, and retries erase. A behavioural queue-based model predicts every output on every falling edge. A final sequence interrupts a boundary shift with pause states and then with a power-on reset in mid-scan.

// File: rtl/jtag_isp_pkg.sv
package jtag_isp_pkg;

  localparam int IR_W = 4;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_RESET    = 4'd0,
    ST_IDLE     = 4'd1,
    ST_DR_SEL   = 4'd2,
    ST_DR_CAP   = 4'd3,
    ST_DR_SHIFT = 4'd4,
    ST_DR_EX1   = 4'd5,
    ST_DR_PAUSE = 4'd6,
    ST_DR_EX2   = 4'd7,
    ST_DR_UPD   = 4'd8,
    ST_IR_SEL   = 4'd9,
    ST_IR_CAP   = 4'd10,
    ST_IR_SHIFT = 4'd11,
    ST_IR_EX1   = 4'd12,
    ST_IR_PAUSE = 4'd13,
    ST_IR_EX2   = 4'd14,
    ST_IR_UPD   = 4'd15
  } tap_st_e;

  typedef enum logic [2:0] {
    K_EXTEST, K_IDCODE, K_SAMPLE, K_HIGHZ, K_BYPASS, K_ISP_EN, K_ISP_OP
  } op_kind_e;

  localparam logic [IR_W-1:0] OPC_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OPC_IDCODE = 4'b0001;
  localparam logic [IR_W-1:0] OPC_SAMPLE = 4'b0010;
  localparam logic [IR_W-1:0] OPC_HIGHZ  = 4'b0101;
  localparam logic [IR_W-1:0] OPC_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};

  function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
    case (s)
      ST_RESET:    return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:     return m ? ST_DR_SEL : ST_IDLE;
      ST_DR_SEL:   return m ? ST_IR_SEL : ST_DR_CAP;
      ST_DR_CAP:   return m ? ST_DR_EX1 : ST_DR_SHIFT;
      ST_DR_SHIFT: return m ? ST_DR_EX1 : ST_DR_SHIFT;
      ST_DR_EX1:   return m ? ST_DR_UPD : ST_DR_PAUSE;
      ST_DR_PAUSE: return m ? ST_DR_EX2 : ST_DR_PAUSE;
      ST_DR_EX2:   return m ? ST_DR_UPD : ST_DR_SHIFT;
      ST_DR_UPD:   return m ? ST_DR_SEL : ST_IDLE;
      ST_IR_SEL:   return m ? ST_RESET  : ST_IR_CAP;
      ST_IR_CAP:   return m ? ST_IR_EX1 : ST_IR_SHIFT;
      ST_IR_SHIFT: return m ? ST_IR_EX1 : ST_IR_SHIFT;
      ST_IR_EX1:   return m ? ST_IR_UPD : ST_IR_PAUSE;
      ST_IR_PAUSE: return m ? ST_IR_EX2 : ST_IR_PAUSE;
      ST_IR_EX2:   return m ? ST_IR_UPD : ST_IR_SHIFT;
      ST_IR_UPD:   return m ? ST_DR_SEL : ST_IDLE;
      default:     return ST_RESET;
    endcase
  endfunction

  function automatic logic is_shift(input tap_st_e s);
    return (s == ST_IR_SHIFT) || (s == ST_DR_SHIFT);
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_isp_pkg::*;
(
  input  logic    tck,
  input  logic    por_n,
  input  logic    tms,
  output tap_st_e state
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_RESET;
    else        state <= tap_next(state, tms);
  end

endmodule

// File: rtl/jtag_ir_unit.sv
module jtag_ir_unit
  import jtag_isp_pkg::*;
#(
  parameter logic [IR_W-1:0] OP_ENABLE  = 4'b1000,
  parameter logic [IR_W-1:0] OP_ERASE   = 4'b1001,
  parameter logic [IR_W-1:0] OP_PROGRAM = 4'b1010,
  parameter logic [IR_W-1:0] OP_VERIFY  = 4'b1011
) (
  input  logic     tck,
  input  logic     por_n,
  input  tap_st_e  state,
  input  logic     tdi,
  output logic     ir_lsb,
  output op_kind_e kind,
  output logic     isp_en,
  output logic [1:0] isp_code
);

  logic [IR_W-1:0] ir_sr;

  // Programming opcodes map to 01/10/11; anything else yields 00.
  function automatic logic [1:0] isp_code_of(input logic [IR_W-1:0] op);
    if (op == OP_ERASE)   return 2'b01;
    if (op == OP_PROGRAM) return 2'b10;
    if (op == OP_VERIFY)  return 2'b11;
    return 2'b00;
  endfunction

  // Permission gates the programming commands; unknown codes fall to bypass.
  function automatic op_kind_e classify(input logic [IR_W-1:0] op, input logic en);
    if (op == OPC_EXTEST) return K_EXTEST;
    if (op == OPC_IDCODE) return K_IDCODE;
    if (op == OPC_SAMPLE) return K_SAMPLE;
    if (op == OPC_HIGHZ)  return K_HIGHZ;
    if (op == OP_ENABLE)  return K_ISP_EN;
    if (isp_code_of(op) != 2'b00) return en ? K_ISP_OP : K_BYPASS;
    return K_BYPASS;
  endfunction

  op_kind_e next_kind;
  assign next_kind = classify(ir_sr, isp_en);
  assign ir_lsb    = ir_sr[0];

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sr    <= IR_CAPTURE;
      kind     <= K_IDCODE;
      isp_en   <= 1'b0;
      isp_code <= 2'b00;
    end else begin
      case (state)
        ST_RESET: begin
          kind     <= K_IDCODE;
          isp_en   <= 1'b0;
          isp_code <= 2'b00;
        end
        ST_IR_CAP:   ir_sr <= IR_CAPTURE;
        ST_IR_SHIFT: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        ST_IR_UPD: begin
          kind     <= next_kind;
          isp_code <= (next_kind == K_ISP_OP) ? isp_code_of(ir_sr) : 2'b00;
          if (ir_sr == OP_ENABLE) isp_en <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/jtag_dr_unit.sv
module jtag_dr_unit
  import jtag_isp_pkg::*;
#(
  parameter int               BSR_LEN = 8,
  parameter logic [ID_W-1:0]  IDCODE  = 32'h1A5C_3093
) (
  input  logic               tck,
  input  logic               por_n,
  input  tap_st_e            state,
  input  logic               tdi,
  input  op_kind_e           kind,
  input  logic [BSR_LEN-1:0] bsr_pins,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] bsr_out,
  output logic               bs_capture,
  output logic               bs_update
);

  logic               byp_q;
  logic [ID_W-1:0]    id_sr;
  logic [BSR_LEN-1:0] bsr_sr;
  logic               sel_id, sel_bsr;

  assign sel_id  = (kind == K_IDCODE);
  assign sel_bsr = (kind == K_EXTEST) || (kind == K_SAMPLE);

  assign bs_capture = sel_bsr && (state == ST_DR_CAP);
  assign bs_update  = sel_bsr && (state == ST_DR_UPD);
  assign dr_lsb     = sel_id ? id_sr[0] : (sel_bsr ? bsr_sr[0] : byp_q);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp_q  <= 1'b0;
      id_sr  <= '0;
      bsr_sr <= '0;
    end else if (state == ST_DR_CAP) begin
      byp_q <= 1'b0;
      if (sel_id)  id_sr  <= IDCODE;
      if (sel_bsr) bsr_sr <= bsr_pins;
    end else if (state == ST_DR_SHIFT) begin
      if (sel_id)                 id_sr  <= {tdi, id_sr[ID_W-1:1]};
      else if (sel_bsr)           bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
      else                        byp_q  <= tdi;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)         bsr_out <= '0;
    else if (bs_update) bsr_out <= bsr_sr;
  end

endmodule

// File: rtl/jtag_isp_tap.sv
module jtag_isp_tap
  import jtag_isp_pkg::*;
#(
  parameter int              BSR_LEN    = 8,
  parameter logic [ID_W-1:0] IDCODE     = 32'h1A5C_3093,
  parameter logic [IR_W-1:0] OP_ENABLE  = 4'b1000,
  parameter logic [IR_W-1:0] OP_ERASE   = 4'b1001,
  parameter logic [IR_W-1:0] OP_PROGRAM = 4'b1010,
  parameter logic [IR_W-1:0] OP_VERIFY  = 4'b1011
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  output logic [3:0]         tap_state,
  input  logic [BSR_LEN-1:0] bsr_pins,
  output logic [BSR_LEN-1:0] bsr_out,
  output logic               bs_capture,
  output logic               bs_update,
  output logic               extest_mode,
  output logic               global_hiz,
  output logic               isp_enabled,
  output logic               isp_cmd_valid,
  output logic [1:0]         isp_cmd
);

  tap_st_e  st;
  op_kind_e kind;
  logic     ir_lsb, dr_lsb, tdo_next;

  jtag_tap_fsm u_fsm (.tck(tck), .por_n(por_n), .tms(tms), .state(st));

  jtag_ir_unit #(
    .OP_ENABLE(OP_ENABLE), .OP_ERASE(OP_ERASE),
    .OP_PROGRAM(OP_PROGRAM), .OP_VERIFY(OP_VERIFY)
  ) u_ir (
    .tck(tck), .por_n(por_n), .state(st), .tdi(tdi),
    .ir_lsb(ir_lsb), .kind(kind), .isp_en(isp_enabled), .isp_code(isp_cmd)
  );

  jtag_dr_unit #(.BSR_LEN(BSR_LEN), .IDCODE(IDCODE)) u_dr (
    .tck(tck), .por_n(por_n), .state(st), .tdi(tdi), .kind(kind),
    .bsr_pins(bsr_pins), .dr_lsb(dr_lsb), .bsr_out(bsr_out),
    .bs_capture(bs_capture), .bs_update(bs_update)
  );

  assign tdo_next = (st == ST_IR_SHIFT) ? ir_lsb : dr_lsb;

  // Output stage re-timed to the falling edge.
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= is_shift(st) ? tdo_next : 1'b0;
      tdo_oe <= is_shift(st);
    end
  end

  assign tap_state     = st;
  assign extest_mode   = (kind == K_EXTEST);
  assign global_hiz    = (kind == K_HIGHZ);
  assign isp_cmd_valid = (kind == K_ISP_OP);

endmodule

// File: rtl/jtag_isp_tap_chk.sv
module jtag_isp_tap_chk
  import jtag_isp_pkg::*;
(
  input logic       tck,
  input logic       por_n,
  input logic       tms,
  input logic       tdo_oe,
  input logic [3:0] tap_state,
  input logic       bs_update,
  input logic       extest_mode,
  input logic       global_hiz,
  input logic       isp_enabled,
  input logic       isp_cmd_valid
);

  assert_tdo_enable_R6: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe == (tap_state == ST_DR_SHIFT || tap_state == ST_IR_SHIFT));

  assert_reset_hold_R1: assert property (@(posedge tck) disable iff (!por_n)
    (tap_state == ST_RESET && tms) |=> tap_state == ST_RESET);

  assert_update_idle_R1: assert property (@(posedge tck) disable iff (!por_n)
    (tap_state == ST_DR_UPD && !tms) |=> tap_state == ST_IDLE);

  assert_perm_rise_R8: assert property (@(posedge tck) disable iff (!por_n)
    $rose(isp_enabled) |-> $past(tap_state) == ST_IR_UPD);

  assert_perm_clear_R8: assert property (@(posedge tck) disable iff (!por_n)
    (tap_state == ST_RESET) |=> !isp_enabled);

  assert_cmd_needs_perm_R9: assert property (@(posedge tck) disable iff (!por_n)
    isp_cmd_valid |-> isp_enabled);

  assert_hiz_excl_R7: assert property (@(posedge tck) disable iff (!por_n)
    global_hiz |-> (!extest_mode && !isp_cmd_valid));

  assert_update_state_R10: assert property (@(posedge tck) disable iff (!por_n)
    bs_update |-> tap_state == ST_DR_UPD);

endmodule

bind jtag_isp_tap jtag_isp_tap_chk u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .tdo_oe(tdo_oe), .tap_state(tap_state),
  .bs_update(bs_update), .extest_mode(extest_mode), .global_hiz(global_hiz),
  .isp_enabled(isp_enabled), .isp_cmd_valid(isp_cmd_valid)
);

// File: tb/sim_jtag_isp_tap.sv
`timescale 1ns/1ps
module sim_jtag_isp_tap;

  localparam int BL = 8;
  localparam logic [31:0] ID_VAL = 32'h1A5C_3093;

  logic tck = 1'b0;
  logic por_n, tms, tdi;
  logic [BL-1:0] bsr_pins;
  wire  tdo, tdo_oe, bs_capture, bs_update, extest_mode, global_hiz;
  wire  isp_enabled, isp_cmd_valid;
  wire  [1:0] isp_cmd;
  wire  [3:0] tap_state;
  wire  [BL-1:0] bsr_out;

  always #2.5 tck = ~tck;

  jtag_isp_tap u0 (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .tap_state(tap_state), .bsr_pins(bsr_pins), .bsr_out(bsr_out),
    .bs_capture(bs_capture), .bs_update(bs_update), .extest_mode(extest_mode),
    .global_hiz(global_hiz), .isp_enabled(isp_enabled),
    .isp_cmd_valid(isp_cmd_valid), .isp_cmd(isp_cmd)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int nx0[16] = '{1,1,3,4,4,6,6,4,1,10,11,11,13,13,11,1};
  int nx1[16] = '{0,2,9,5,5,8,7,8,2,0,12,12,15,14,15,2};
  int m_st, m_kind, m_code;   // kinds: 0 ext,1 id,2 sample,3 hiz,4 byp,5 enable,6 isp
  bit m_perm;
  bit mq[$];
  logic [BL-1:0] m_bout;

  task automatic model_reset();
    m_st = 0; m_kind = 1; m_code = 0; m_perm = 0; m_bout = '0; mq.delete();
  endtask

  task automatic model_edge(input bit t, input bit d);
    int op;
    case (m_st)
      0: begin m_kind = 1; m_perm = 0; m_code = 0; end
      10: begin mq.delete(); mq.push_back(1); mq.push_back(0); mq.push_back(0); mq.push_back(0); end
      11, 4: begin void'(mq.pop_front()); mq.push_back(d); end
      15: begin
        op = mq[0] + 2*mq[1] + 4*mq[2] + 8*mq[3];
        m_code = 0;
        if (op == 0) m_kind = 0;
        else if (op == 1) m_kind = 1;
        else if (op == 2) m_kind = 2;
        else if (op == 5) m_kind = 3;
        else if (op == 8) m_kind = 5;
        else if (op >= 9 && op <= 11) begin
          if (m_perm) begin m_kind = 6; m_code = op - 8; end
          else m_kind = 4;
        end else m_kind = 4;
        if (op == 8) m_perm = 1;
      end
      3: begin
        mq.delete();
        if (m_kind == 1) for (int i = 0; i < 32; i++) mq.push_back(ID_VAL[i]);
        else if (m_kind == 0 || m_kind == 2) for (int i = 0; i < BL; i++) mq.push_back(bsr_pins[i]);
        else mq.push_back(0);
      end
      8: if (m_kind == 0 || m_kind == 2) for (int i = 0; i < BL; i++) m_bout[i] = mq[i];
      default: ;
    endcase
    m_st = t ? nx1[m_st] : nx0[m_st];
  endtask

  task automatic compare();
    bit sh, bsel;
    sh = (m_st == 4 || m_st == 11);
    bsel = (m_kind == 0 || m_kind == 2);
    chk("R1", "tap_state", tap_state, m_st);
    chk("R6", "tdo_oe", tdo_oe, sh);
    if (sh) chk("R6", "tdo", tdo, mq[0]);
    chk("R7", "global_hiz", global_hiz, m_kind == 3);
    chk("R8", "isp_enabled", isp_enabled, m_perm);
    chk("R9", "isp_cmd_valid", isp_cmd_valid, m_kind == 6);
    chk("R9", "isp_cmd", isp_cmd, m_code);
    chk("R10", "extest_mode", extest_mode, m_kind == 0);
    chk("R10", "bs_capture", bs_capture, bsel && m_st == 3);
    chk("R10", "bs_update", bs_update, bsel && m_st == 8);
    chk("R10", "bsr_out", bsr_out, m_bout);
  endtask

  task automatic tick(input bit t, input bit d);
    tms = t; tdi = d;
    @(posedge tck);
    if (por_n) model_edge(t, d);
    @(negedge tck); #1;
    compare();
  endtask

  task automatic ir_scan(input logic [3:0] op, output logic [3:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin cap[i] = tdo; tick(i == 3, op[i]); end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin dout[i] = tdo; tick(i == n-1, din[i]); end
    tick(1, 0); tick(0, 0);
  endtask

  logic [3:0]  cap;
  logic [63:0] dout;

  initial begin
    por_n = 0; tms = 1; tdi = 0; bsr_pins = '0;
    model_reset();
    #12;
    chk("R2", "reset state", tap_state, 0);
    chk("R2", "reset tdo_oe", tdo_oe, 0);
    chk("R2", "reset perm", isp_enabled, 0);
    @(negedge tck); #1; por_n = 1;
    for (int i = 0; i < 5; i++) tick(1, 0);          // R1 stays in reset
    tick(0, 0);
    dr_scan(32, 64'h0, dout);
    chk("R5", "idcode word", dout[31:0], ID_VAL);
    ir_scan(4'hF, cap);
    chk("R3", "IR capture pattern", cap, 4'b0001);
    dr_scan(4, 64'hB, dout);
    chk("R4", "bypass one-clock delay", dout[3:0], 4'b0110);
    ir_scan(4'h5, cap);
    chk("R7", "highz request", global_hiz, 1);
    dr_scan(3, 64'h6, dout);
    chk("R7", "highz uses bypass", dout[2:0], 3'b100);
    ir_scan(4'h7, cap);
    dr_scan(2, 64'h3, dout);
    chk("R4", "unassigned opcode bypass", dout[1:0], 2'b10);
    ir_scan(4'h9, cap);
    chk("R9", "erase without enable rejected", isp_cmd_valid, 0);
    dr_scan(2, 64'h1, dout);
    chk("R9", "rejected erase acts as bypass", dout[1:0], 2'b10);
    ir_scan(4'h8, cap);
    chk("R8", "enable grants permission", isp_enabled, 1);
    ir_scan(4'hA, cap);
    chk("R9", "program accepted", {isp_cmd_valid, isp_cmd}, 3'b110);
    ir_scan(4'hF, cap);
    chk("R8", "permission survives bypass", isp_enabled, 1);
    ir_scan(4'hB, cap);
    chk("R9", "verify accepted", {isp_cmd_valid, isp_cmd}, 3'b111);
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0);
    chk("R8", "permission cleared by reset state", isp_enabled, 0);
    ir_scan(4'h9, cap);
    chk("R9", "erase rejected after reset state", isp_cmd_valid, 0);
    bsr_pins = 8'hA5;
    ir_scan(4'h2, cap);
    dr_scan(BL, 64'h3C, dout);
    chk("R10", "sample captures pins", dout[BL-1:0], 8'hA5);
    chk("R10", "sample update", bsr_out, 8'h3C);
    ir_scan(4'h0, cap);
    chk("R10", "extest select", extest_mode, 1);
    bsr_pins = 8'h5A;
    tick(1, 0); tick(0, 0); tick(0, 0);              // into shift-DR
    for (int i = 0; i < 3; i++) begin dout[i] = tdo; tick(i == 2, 1'(8'hC3 >> i)); end
    tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);  // pause, pause, exit2, shift
    for (int i = 3; i < BL; i++) begin dout[i] = tdo; tick(i == BL-1, 1'(8'hC3 >> i)); end
    tick(1, 0); tick(0, 0);
    chk("R10", "extest capture across pause", dout[BL-1:0], 8'h5A);
    chk("R1", "pause path update", bsr_out, 8'hC3);
    tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);  // mid shift
    por_n = 0; #1;
    chk("R2", "async por state", tap_state, 0);
    chk("R2", "async por instruction", extest_mode, 0);
    chk("R2", "async por tdo_oe", tdo_oe, 0);
    model_reset();
    m_bout = 8'h00;
    @(negedge tck); #1; por_n = 1;
    tick(1, 0); tick(0, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge tck) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule